// File: doc/BRIEF.md
# Credit and On/Off Flow-Control Tracker for a Router Output Port

This block sits on the output side of a router port and decides, for each downstream virtual channel, whether a flit may be sent this cycle. In its default credit mode it holds one counter per virtual channel. The counter starts at the downstream buffer depth and always equals the number of free slots downstream for that channel. A granted send takes one credit. A credit returned by the downstream node gives one back after a fixed, configurable return-path delay. A channel is ready only while its counter is above zero. A credit that would push a counter past the buffer depth saturates the counter and raises a sticky error flag.

A parameter selects an alternative on/off mode. In that mode the counters are not built. Each channel instead follows a stop level that the downstream side raises when its buffer nears full. The level passes through the same return-path delay and then gates readiness. This mode saves the counters. In exchange, the downstream threshold must leave room for every flit that is still in flight while the stop level travels back.

Credit mode keeps the link fully busy only when the buffer depth is at least the credit round trip in cycles. The round trip is the downstream return latency plus the return-path delay plus one cycle for the counter update.

Top module: `credit_tracker`

## Requirements
- R1: After reset, in credit mode every per-channel count equals BUF_DEPTH, every bit of `vc_ready` is 1 and `ovf_err` is 0. A count never exceeds BUF_DEPTH.
- R2: `snd_grant` is `snd_req` AND `vc_ready[snd_vc]` in the same cycle. A grant without a coinciding credit lowers that channel's count by one at the next clock edge.
- R3: A credit on `crd_ret`/`crd_vc` sampled at clock edge k raises that channel's count at edge k+RET_DELAY.
- R4: When a delayed credit and a grant hit the same channel at the same edge, its count is left unchanged.
- R5: A channel whose count is 0 shows `vc_ready` low. A request on it is not granted, and the count stays 0 until a credit arrives.
- R6: A credit reaching a channel whose count already equals BUF_DEPTH leaves the count at BUF_DEPTH and sets `ovf_err`. `ovf_err` then stays 1 until reset.
- R7: Take a downstream node that returns each credit L cycles after the send. With requests held on one channel, the round trip is RT = L+RET_DELAY+1. A grant occurs every cycle when BUF_DEPTH >= RT. Otherwise BUF_DEPTH grants occur in each RT cycles.
- R8: In on/off mode (MODE = FC_ONOFF), `vc_ready[v]` is the inverse of `stop_lvl[v]` as sampled RET_DELAY edges earlier (1 = stop). Requests on a stopped channel are not granted.
- R9: In on/off mode `crd_cnt` reads all zero, `ovf_err` is 0, and credit returns have no effect.
- R10: Sends and credits on one channel leave the counts of all other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_req | input | 1 | Upstream wants to send a flit |
| snd_vc | input | VC_W | Virtual channel of the requested flit |
| crd_ret | input | 1 | One credit returned by the downstream node |
| crd_vc | input | VC_W | Virtual channel of the returned credit |
| stop_lvl | input | NUM_VC | Per-channel downstream almost-full level, used in on/off mode |
| vc_ready | output | NUM_VC | Channel may send this cycle |
| snd_grant | output | 1 | Requested flit is sent this cycle |
| crd_cnt | output | NUM_VC*CNT_W | Free-slot count per channel, channel v at bits [v*CNT_W +: CNT_W] |
| ovf_err | output | 1 | Sticky credit overflow flag |

## Verification
Assertions in the counter bank check every cycle that a count stays within the buffer depth. They also check the effect of each edge on each channel: down by one on a lone grant, up by one on a lone credit, unchanged on both together, pinned at zero while empty, and a sticky overflow flag. Some properties span many cycles, and only the bench scenarios can show them. These are the throughput bound set by the round trip against the depth, the exact latency of the return path, the on/off gating seen at the ports, and the isolation between channels. The bench checks these with a downstream model whose return latency it can vary.

// File: rtl/tracker_pkg.sv
package tracker_pkg;

    typedef enum logic {
        FC_CREDIT = 1'b0,
        FC_ONOFF  = 1'b1
    } fc_mode_e;

    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/tracker_delay.sv
module tracker_delay #(
    parameter int W      = 1,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_wire
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign q = d;
        end else begin : g_pipe
            logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

            always_comb begin
                pipe_d[0] = d;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign q = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/credit_bank.sv
module credit_bank #(
    parameter int NUM_VC    = 4,
    parameter int BUF_DEPTH = 4,
    parameter int VC_W      = $clog2(NUM_VC),
    parameter int CNT_W     = tracker_pkg::cnt_width(BUF_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dec_en,
    input  logic [VC_W-1:0]         dec_vc,
    input  logic                    inc_en,
    input  logic [VC_W-1:0]         inc_vc,
    output logic [NUM_VC*CNT_W-1:0] cnt_flat,
    output logic [NUM_VC-1:0]       nonzero,
    output logic                    ovf
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_DEPTH);

    typedef struct packed {
        logic [NUM_VC-1:0][CNT_W-1:0] cnt;
        logic                         ovf;
    } bank_st_t;

    bank_st_t          st_d, st_q;
    logic [NUM_VC-1:0] dec_hit, inc_hit;

    always_comb begin
        st_d = st_q;
        for (int v = 0; v < NUM_VC; v++) begin
            dec_hit[v] = dec_en && (dec_vc == VC_W'(v)) && (st_q.cnt[v] != '0);
            inc_hit[v] = inc_en && (inc_vc == VC_W'(v));
            if (inc_hit[v] && !dec_hit[v]) begin
                if (st_q.cnt[v] == FULL) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.cnt[v] = st_q.cnt[v] + CNT_W'(1);
                end
            end else if (dec_hit[v] && !inc_hit[v]) begin
                st_d.cnt[v] = st_q.cnt[v] - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VC; v++) begin
                st_q.cnt[v] <= FULL;
            end
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_flat = st_q.cnt;
    assign ovf      = st_q.ovf;

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_nz
            assign nonzero[v] = (st_q.cnt[v] != '0);

            AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.cnt[v] <= FULL); // R1

            AST_SEND_DEC: assert property (@(posedge clk) disable iff (!rst_n)
                (dec_hit[v] && !inc_hit[v]) |=> st_q.cnt[v] == $past(st_q.cnt[v]) - CNT_W'(1)); // R2

            AST_RET_INC: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_hit[v] && !dec_hit[v] && st_q.cnt[v] != FULL)
                |=> st_q.cnt[v] == $past(st_q.cnt[v]) + CNT_W'(1)); // R3

            AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_hit[v] && dec_hit[v]) |=> $stable(st_q.cnt[v])); // R4

            AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.cnt[v] == '0 && !inc_hit[v]) |=> st_q.cnt[v] == '0); // R5
        end
    endgenerate

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf); // R6

endmodule

// File: rtl/credit_tracker.sv
module credit_tracker #(
    parameter int                   NUM_VC    = 4,
    parameter int                   BUF_DEPTH = 4,
    parameter int                   RET_DELAY = 1,
    parameter tracker_pkg::fc_mode_e MODE     = tracker_pkg::FC_CREDIT,
    parameter int                   VC_W      = $clog2(NUM_VC),
    parameter int                   CNT_W     = tracker_pkg::cnt_width(BUF_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snd_req,
    input  logic [VC_W-1:0]         snd_vc,
    input  logic                    crd_ret,
    input  logic [VC_W-1:0]         crd_vc,
    input  logic [NUM_VC-1:0]       stop_lvl,
    output logic [NUM_VC-1:0]       vc_ready,
    output logic                    snd_grant,
    output logic [NUM_VC*CNT_W-1:0] crd_cnt,
    output logic                    ovf_err
);

    assign snd_grant = snd_req && vc_ready[snd_vc];

    generate
        if (MODE == tracker_pkg::FC_CREDIT) begin : g_credit
            logic [VC_W:0] ret_in, ret_out;
            logic [NUM_VC-1:0] unused_stop;

            assign unused_stop = stop_lvl;
            assign ret_in      = {crd_ret, crd_vc};

            tracker_delay #(.W(VC_W + 1), .STAGES(RET_DELAY)) u_ret_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (ret_in),
                .q     (ret_out)
            );

            credit_bank #(
                .NUM_VC    (NUM_VC),
                .BUF_DEPTH (BUF_DEPTH),
                .VC_W      (VC_W),
                .CNT_W     (CNT_W)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .dec_en   (snd_grant),
                .dec_vc   (snd_vc),
                .inc_en   (ret_out[VC_W]),
                .inc_vc   (ret_out[VC_W-1:0]),
                .cnt_flat (crd_cnt),
                .nonzero  (vc_ready),
                .ovf      (ovf_err)
            );
        end else begin : g_onoff
            logic [NUM_VC-1:0] stop_out;
            logic [VC_W:0]     unused_ret;

            assign unused_ret = {crd_ret, crd_vc};

            tracker_delay #(.W(NUM_VC), .STAGES(RET_DELAY)) u_stop_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (stop_lvl),
                .q     (stop_out)
            );

            assign vc_ready = ~stop_out;
            assign crd_cnt  = '0;
            assign ovf_err  = 1'b0;

            AST_STOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
                (snd_req && stop_out[snd_vc]) |-> !snd_grant); // R8
        end
    endgenerate

endmodule

// File: tb/tb_credit_tracker.sv
`timescale 1ns/100ps
module tb_credit_tracker;
    import tracker_pkg::*;

    localparam int NV = 4;
    localparam int DEP = 4;
    localparam int RD = 1;
    localparam int VW = 2;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          snd_req = 0, crd_ret = 0;
    logic [VW-1:0] snd_vc = 0, crd_vc = 0;
    logic [NV-1:0] stop_lvl = 0;
    logic [NV-1:0] vc_ready;
    logic          snd_grant, ovf_err;
    logic [NV*CW-1:0] crd_cnt;

    logic          o_req = 0, o_crd = 0;
    logic [VW-1:0] o_vc = 0, o_cvc = 0;
    logic [NV-1:0] o_stop = 0, o_ready;
    logic          o_grant, o_ovf;
    logic [NV*CW-1:0] o_cnt;

    credit_tracker #(.NUM_VC(NV), .BUF_DEPTH(DEP), .RET_DELAY(RD), .MODE(FC_CREDIT)) dut (
        .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_vc(snd_vc),
        .crd_ret(crd_ret), .crd_vc(crd_vc), .stop_lvl(stop_lvl),
        .vc_ready(vc_ready), .snd_grant(snd_grant), .crd_cnt(crd_cnt), .ovf_err(ovf_err));

    credit_tracker #(.NUM_VC(NV), .BUF_DEPTH(DEP), .RET_DELAY(RD), .MODE(FC_ONOFF)) dut_onoff (
        .clk(clk), .rst_n(rst_n), .snd_req(o_req), .snd_vc(o_vc),
        .crd_ret(o_crd), .crd_vc(o_cvc), .stop_lvl(o_stop),
        .vc_ready(o_ready), .snd_grant(o_grant), .crd_cnt(o_cnt), .ovf_err(o_ovf));

    typedef enum int {K_CNT, K_RDY, K_GRT, K_OVF, K_OCNT, K_ORDY, K_OGRT, K_OOVF, K_VAL} kind_e;
    typedef struct {
        string req;
        kind_e kind;
        int    vc;
        int    exp;
        int    act;
    } item_t;

    item_t sb_q[$];
    event  mon_ev;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Monitor: pops expected items and compares them with the design outputs
    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                int got;
                it = sb_q.pop_front();
                case (it.kind)
                    K_CNT:  got = int'(crd_cnt[it.vc*CW +: CW]);
                    K_RDY:  got = int'(vc_ready[it.vc]);
                    K_GRT:  got = int'(snd_grant);
                    K_OVF:  got = int'(ovf_err);
                    K_OCNT: got = int'(o_cnt);
                    K_ORDY: got = int'(o_ready[it.vc]);
                    K_OGRT: got = int'(o_grant);
                    K_OOVF: got = int'(o_ovf);
                    default: got = it.act;
                endcase
                checks++;
                if (got != it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%s vc=%0d actual=%0d expected=%0d",
                             it.req, it.kind.name(), it.vc, got, it.exp);
                end
            end
        end
    end

    task automatic expect_item(string req, kind_e kind, int vc, int exp, int act = 0);
        item_t it;
        it.req = req; it.kind = kind; it.vc = vc; it.exp = exp; it.act = act;
        sb_q.push_back(it);
        -> mon_ev;
        #0.1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Stream requests on VC0 against a downstream model with return latency lat
    task automatic run_stream(string req, int lat, int ncyc, int exp_sends);
        bit sent[256];
        int sends = 0;
        for (int k = 0; k < ncyc + lat; k++) begin
            crd_ret = (k >= lat) && sent[k-lat];
            crd_vc  = 0;
            snd_req = (k < ncyc);
            snd_vc  = 0;
            #1;
            sent[k] = snd_grant;
            if (k < ncyc && snd_grant) sends++;
            @(posedge clk);
            @(negedge clk);
        end
        crd_ret = 0;
        snd_req = 0;
        repeat (RD + 1) tick();
        expect_item(req, K_VAL, 0, exp_sends, sends);
        expect_item(req, K_CNT, 0, DEP);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // R1 reset state, R9 on/off outputs
        for (int v = 0; v < NV; v++) begin
            expect_item("R1", K_CNT, v, DEP);
            expect_item("R1", K_RDY, v, 1);
        end
        expect_item("R1", K_OVF, 0, 0);
        expect_item("R9", K_OCNT, 0, 0);

        // R2 send on VC1, R10 others untouched
        snd_req = 1; snd_vc = 1;
        expect_item("R2", K_GRT, 1, 1);
        tick();
        snd_req = 0;
        expect_item("R2", K_CNT, 1, DEP - 1);
        expect_item("R10", K_CNT, 0, DEP);
        expect_item("R10", K_CNT, 2, DEP);

        // R3 credit on VC1 takes RET_DELAY+1 edges to appear
        crd_ret = 1; crd_vc = 1;
        tick();
        crd_ret = 0;
        expect_item("R3", K_CNT, 1, DEP - 1);
        tick();
        expect_item("R3", K_CNT, 1, DEP);

        // R5 drain VC2 to zero, then request is refused
        snd_req = 1; snd_vc = 2;
        repeat (DEP) tick();
        expect_item("R5", K_CNT, 2, 0);
        expect_item("R5", K_RDY, 2, 0);
        expect_item("R5", K_GRT, 2, 0);
        tick();
        snd_req = 0;
        expect_item("R5", K_CNT, 2, 0);
        expect_item("R10", K_CNT, 3, DEP);
        crd_ret = 1; crd_vc = 2;
        repeat (DEP) tick();
        crd_ret = 0;
        repeat (RD) tick();
        expect_item("R3", K_CNT, 2, DEP);

        // R4 delayed credit and grant coincide on VC3
        snd_req = 1; snd_vc = 3;
        tick();
        snd_req = 0;
        expect_item("R4", K_CNT, 3, DEP - 1);
        crd_ret = 1; crd_vc = 3;
        tick();
        crd_ret = 0;
        snd_req = 1; snd_vc = 3;
        expect_item("R4", K_GRT, 3, 1);
        tick();
        snd_req = 0;
        expect_item("R4", K_CNT, 3, DEP - 1);
        tick();
        expect_item("R4", K_CNT, 3, DEP - 1);
        crd_ret = 1; crd_vc = 3;
        tick();
        crd_ret = 0;
        tick();
        expect_item("R3", K_CNT, 3, DEP);

        // R7 throughput: RT = lat+RD+1
        run_stream("R7", 2, 40, 40);
        run_stream("R7", 3, 40, 32);

        // R6 overflow saturates and sticks
        expect_item("R6", K_OVF, 0, 0);
        crd_ret = 1; crd_vc = 0;
        tick();
        crd_ret = 0;
        tick();
        expect_item("R6", K_CNT, 0, DEP);
        expect_item("R6", K_OVF, 0, 1);
        repeat (3) tick();
        expect_item("R6", K_OVF, 0, 1);

        // R8 on/off gating
        o_stop[1] = 1'b1;
        expect_item("R8", K_ORDY, 1, 1);
        tick();
        expect_item("R8", K_ORDY, 1, 0);
        expect_item("R8", K_ORDY, 0, 1);
        o_req = 1; o_vc = 1;
        expect_item("R8", K_OGRT, 1, 0);
        o_vc = 0;
        expect_item("R8", K_OGRT, 0, 1);
        o_req = 0;
        o_stop[1] = 1'b0;
        tick();
        expect_item("R8", K_ORDY, 1, 1);

        // R9 credits ignored in on/off mode
        o_crd = 1; o_cvc = 2;
        repeat (3) tick();
        o_crd = 0;
        expect_item("R9", K_OCNT, 0, 0);
        expect_item("R9", K_OOVF, 0, 0);

        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule